// File: doc/BRIEF.md
# SAR ADC Timing Sequencer

This block sequences a successive-approximation analog-to-digital conversion. A one-cycle start strobe, accepted only while the block is idle and only for a channel in the supported range, latches the channel number, the resolution mode and an 8-bit timing byte. The block then holds the sample-and-hold switch closed for a programmed number of cycles. After that it runs a binary search, from the most significant bit down, over an 8-bit or 10-bit code.

During the search, each bit occupies one slot of programmed length. The block drives the tentative code on the DAC output and reads a single comparator bit from outside at the end of the slot. A fixed three-cycle tail follows the last slot. The finished code is then written to the result register, together with a one-cycle done pulse.

The timing byte packs two fields. The upper three bits select the sample length. The lower five bits select the length of each approximation slot. Values below the legal minimum of either field are raised to that minimum.

Top module: `sar_sequencer`

## Requirements
- R1: After reset, busy_o, sample_o and done_o are 0, and dac_o and result_o are all zeros.
- R2: A start_i pulse seen on a clock edge while idle, with chan_i in 0..12, makes busy_o high from the next cycle. chan_o shows the latched channel for the whole conversion.
- R3: A start_i pulse with chan_i in 13..15 is ignored: busy_o stays 0 and no done pulse follows.
- R4: The sample field S is timing_i[7:5], and a value of 0 is treated as 1. sample_o is high for exactly 8*S+2 cycles, starting with the first busy cycle.
- R5: The conversion field C is timing_i[4:0], and values 0 and 1 are treated as 2. With B = 10 when mode10_i=1 and B = 8 when mode10_i=0, busy_o stays high for exactly (8*S+2) + (2*B*(C+1)+3) cycles.
- R6: In 10-bit mode, bits are decided from bit 9 down to bit 0. Each bit is kept when comp_i=1 (input at or above dac_o) at the end of its slot. With a comparator that reports input >= dac_o, result_o equals the input level for every level 0..1023.
- R7: In 8-bit mode, only bits 7..0 are searched: dac_o[9:8] and result_o[9:8] stay 0, and result_o equals the input level for every level 0..255.
- R8: A start_i pulse while busy_o is high is ignored. The channel, mode, timing and length of the conversion in progress do not change.
- R9: done_o is high for exactly one cycle: the first cycle after busy_o falls. result_o changes only in that cycle and holds its value otherwise.
- R10: dac_o is all zeros whenever the block is idle or sampling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one oscillator period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request strobe |
| chan_i | input | 4 | Requested input channel |
| mode10_i | input | 1 | 1 selects 10-bit, 0 selects 8-bit resolution |
| timing_i | input | 8 | Sample field in [7:5], slot field in [4:0] |
| comp_i | input | 1 | Comparator: 1 when input is at or above dac_o |
| sample_o | output | 1 | Sample-and-hold switch closed |
| dac_o | output | 10 | Tentative code for the DAC ladder |
| chan_o | output | 4 | Channel of the current or last conversion |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 10 | Last completed conversion code |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a second start request arriving in the middle of a running search. That request carries a different channel, mode and timing byte, and any leak of those values would corrupt the code or the phase lengths. The bench launches a 10-bit conversion of a level above 255 and fires a conflicting 8-bit request partway through. It then checks the channel, the total busy length and the full 10-bit result. The clamp corners are reached by sweeping every sample field value and the slot field values 1, 2, 17 and 31 in both modes. The cycle counts with busy and sample high are measured at the ports.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int SAR_RES_MAX = 10;
    localparam int SAR_CNT_W   = 8;
    localparam int SAR_IDX_W   = 4;
    localparam int SAR_CH_W    = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONV,
        ST_TAIL
    } sar_state_e;

    typedef struct packed {
        sar_state_e                st;
        logic [SAR_CNT_W-1:0]      cnt;
        logic [SAR_IDX_W-1:0]      idx;
        logic [SAR_RES_MAX-1:0]    code;
        logic                      mode10;
        logic [SAR_CNT_W-1:0]      slot;
        logic [SAR_CH_W-1:0]       chan;
        logic [SAR_RES_MAX-1:0]    result;
        logic                      done;
    } sar_regs_t;
endpackage

// File: rtl/sar_phase_calc.sv
module sar_phase_calc #(
    parameter int SAM_W    = 3,
    parameter int CONV_W   = 5,
    parameter int SAM_MIN  = 1,
    parameter int CONV_MIN = 2,
    parameter int CNT_W    = 8
) (
    input  logic [SAM_W+CONV_W-1:0] timing_i,
    output logic [CNT_W-1:0]        sample_load_o,
    output logic [CNT_W-1:0]        slot_load_o
);
    logic [SAM_W-1:0]  sam_raw;
    logic [CONV_W-1:0] conv_raw;
    logic [SAM_W-1:0]  sam_c;
    logic [CONV_W-1:0] conv_c;

    always_comb begin
        sam_raw  = timing_i[SAM_W+CONV_W-1:CONV_W];
        conv_raw = timing_i[CONV_W-1:0];
        sam_c    = (int'(sam_raw)  < SAM_MIN)  ? SAM_W'(SAM_MIN)   : sam_raw;
        conv_c   = (int'(conv_raw) < CONV_MIN) ? CONV_W'(CONV_MIN) : conv_raw;
        // counters run down to zero, so loads are length minus one
        sample_load_o = (CNT_W'(sam_c) << 3) | CNT_W'(1);
        slot_load_o   = (CNT_W'(conv_c) << 1) | CNT_W'(1);
    end
endmodule

// File: rtl/sar_code_step.sv
module sar_code_step #(
    parameter int RES   = 10,
    parameter int IDX_W = 4
) (
    input  logic [RES-1:0]   code_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             comp_i,
    output logic [RES-1:0]   trial_o,
    output logic [RES-1:0]   kept_o
);
    logic [RES-1:0] bit_mask;

    always_comb begin
        bit_mask = {{(RES-1){1'b0}}, 1'b1} << idx_i;
        trial_o  = code_i | bit_mask;
        kept_o   = comp_i ? trial_o : code_i;
    end
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int NUM_CH  = 13,
    parameter int RES_HI  = SAR_RES_MAX,
    parameter int RES_LO  = 8,
    parameter int TIME_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [SAR_CH_W-1:0]   chan_i,
    input  logic                  mode10_i,
    input  logic [TIME_W-1:0]     timing_i,
    input  logic                  comp_i,
    output logic                  sample_o,
    output logic [RES_HI-1:0]     dac_o,
    output logic [SAR_CH_W-1:0]   chan_o,
    output logic                  busy_o,
    output logic [RES_HI-1:0]     result_o,
    output logic                  done_o
);
    localparam logic [SAR_IDX_W-1:0] TOP_HI = SAR_IDX_W'(RES_HI - 1);
    localparam logic [SAR_IDX_W-1:0] TOP_LO = SAR_IDX_W'(RES_LO - 1);
    localparam logic [SAR_CNT_W-1:0] TAIL_LOAD = SAR_CNT_W'(2);

    sar_regs_t r_q, r_d;

    logic [SAR_CNT_W-1:0] sample_load, slot_load;
    logic [RES_HI-1:0]    trial, kept;
    logic                 accept;

    sar_phase_calc #(
        .SAM_W   (3),
        .CONV_W  (TIME_W - 3),
        .SAM_MIN (1),
        .CONV_MIN(2),
        .CNT_W   (SAR_CNT_W)
    ) u_phase (
        .timing_i     (timing_i),
        .sample_load_o(sample_load),
        .slot_load_o  (slot_load)
    );

    sar_code_step #(
        .RES  (RES_HI),
        .IDX_W(SAR_IDX_W)
    ) u_step (
        .code_i (r_q.code),
        .idx_i  (r_q.idx),
        .comp_i (comp_i),
        .trial_o(trial),
        .kept_o (kept)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        accept   = start_i && (r_q.st == ST_IDLE) && (int'(chan_i) < NUM_CH);
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st     = ST_SAMPLE;
                    r_d.cnt    = sample_load;
                    r_d.slot   = slot_load;
                    r_d.mode10 = mode10_i;
                    r_d.chan   = chan_i;
                    r_d.code   = '0;
                end
            end
            ST_SAMPLE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_CONV;
                    r_d.cnt = r_q.slot;
                    r_d.idx = r_q.mode10 ? TOP_HI : TOP_LO;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_CONV: begin
                if (r_q.cnt == '0) begin
                    r_d.code = kept;
                    if (r_q.idx == '0) begin
                        r_d.st  = ST_TAIL;
                        r_d.cnt = TAIL_LOAD;
                    end else begin
                        r_d.idx = r_q.idx - 1'b1;
                        r_d.cnt = r_q.slot;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                if (r_q.cnt == '0) begin
                    r_d.st     = ST_IDLE;
                    r_d.result = r_q.code;
                    r_d.done   = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy_o   = (r_q.st != ST_IDLE);
        sample_o = (r_q.st == ST_SAMPLE);
        chan_o   = r_q.chan;
        result_o = r_q.result;
        done_o   = r_q.done;
        case (r_q.st)
            ST_CONV: dac_o = trial;
            ST_TAIL: dac_o = r_q.code;
            default: dac_o = '0;
        endcase
    end

    // done is a single-cycle pulse (R9)
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // done follows the falling edge of busy (R9)
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    // result only moves together with done (R9)
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
    // sampling only happens inside a busy window (R4)
    p_sample_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> busy_o);
    // channel frozen while a conversion runs (R8)
    p_chan_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(chan_o));
    // low resolution never drives the upper ladder bits (R7)
    p_dac_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !r_q.mode10) |-> ((dac_o >> RES_LO) == '0));
    // ladder is parked while idle or sampling (R10)
    p_dac_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o || sample_o) |-> (dac_o == '0));
endmodule

// File: tb/sar_sequencer_test.sv
module sar_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] chan = 4'd0;
    logic       mode10 = 1'b0;
    logic [7:0] timing = 8'h22;
    logic       comp;
    logic       sample;
    logic [9:0] dac;
    logic [3:0] chan_out;
    logic       busy;
    logic [9:0] result;
    logic       done;

    int vin = 0;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign comp = (vin >= int'(dac));

    sar_sequencer uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .chan_i  (chan),
        .mode10_i(mode10),
        .timing_i(timing),
        .comp_i  (comp),
        .sample_o(sample),
        .dac_o   (dac),
        .chan_o  (chan_out),
        .busy_o  (busy),
        .result_o(result),
        .done_o  (done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_busy(input int t, input bit m10);
        int s = (t >> 5) & 7;
        int c = t & 31;
        if (s < 1) s = 1;
        if (c < 2) c = 2;
        return (8 * s + 2) + (2 * (m10 ? 10 : 8) * (c + 1) + 3);
    endfunction

    function automatic int exp_sample(input int t);
        int s = (t >> 5) & 7;
        if (s < 1) s = 1;
        return 8 * s + 2;
    endfunction

    // Drive a start pulse, then measure the busy window at negedges.
    task automatic run(input int ch, input bit m10, input int t, input int level,
                       output int nbusy, output int nsample, output int res,
                       output int dn_after, output int dn_next, output int dac_hi);
        vin = level;
        chan = 4'(ch); mode10 = m10; timing = 8'(t);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        nbusy = 0; nsample = 0; dac_hi = 0;
        while (busy && nbusy < 2000) begin
            nbusy++;
            if (sample) nsample++;
            if (dac[9:8] != 2'b00) dac_hi = 1;
            @(negedge clk);
        end
        res = int'(result);
        dn_after = int'(done);
        @(negedge clk);
        dn_next = int'(done);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nb, ns, rs, da, dn, dh;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 sample", int'(sample), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 dac", int'(dac), 0);
        chk("R1 result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 start and channel latch
        run(12, 1'b1, 8'h22, 500, nb, ns, rs, da, dn, dh);
        chk("R2 chan_o", int'(chan_out), 12);
        chk("R2 busy length", nb, exp_busy(8'h22, 1'b1));

        // R3 out-of-range channels ignored
        for (int c = 13; c < 16; c++) begin
            chan = 4'(c); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            chk("R3 busy", int'(busy), 0);
            chk("R3 done", int'(done), 0);
            chk("R3 chan_o", int'(chan_out), 12);
        end

        // R4 / R5 timing sweep with clamping, both modes
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 4; k++) begin
                int cv = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 17 : 31;
                bit m = bit'(s & 1);
                int t = (s << 5) | cv;
                run(s % 13, m, t, 77, nb, ns, rs, da, dn, dh);
                chk("R4 sample length", ns, exp_sample(t));
                chk("R5 busy length", nb, exp_busy(t, m));
                chk("R9 done after busy", da, 1);
                chk("R9 done single", dn, 0);
                chk("R6/R7 result", rs, 77);
            end
        end

        // R6 exhaustive 10-bit sweep
        for (int v = 0; v < 1024; v++) begin
            run(v % 13, 1'b1, 8'h22, v, nb, ns, rs, da, dn, dh);
            chk("R6 result 10-bit", rs, v);
        end

        // R7 exhaustive 8-bit sweep
        for (int v = 0; v < 256; v++) begin
            run(v % 13, 1'b0, 8'h22, v, nb, ns, rs, da, dn, dh);
            chk("R7 result 8-bit", rs, v);
            chk("R7 dac upper bits", dh, 0);
        end
        // R7 level beyond 8-bit range saturates to full scale
        run(1, 1'b0, 8'h22, 1000, nb, ns, rs, da, dn, dh);
        chk("R7 saturate", rs, 255);

        // R8 start while busy is ignored
        begin
            int cnt = 0;
            vin = 700;
            chan = 4'd3; mode10 = 1'b1; timing = 8'h43;
            start = 1'b1;
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            while (busy && cnt < 2000) begin
                cnt++;
                if (cnt == 20 || cnt == 150) begin
                    chan = 4'd7; mode10 = 1'b0; timing = 8'hE1;
                    start = 1'b1;
                end else begin
                    start = 1'b0;
                end
                if (chan_out != 4'd3) begin
                    chk("R8 chan during busy", int'(chan_out), 3);
                end
                @(negedge clk);
            end
            start = 1'b0;
            chk("R8 busy length", cnt, exp_busy(8'h43, 1'b1));
            chk("R8 result", int'(result), 700);
            chk("R8 chan_o", int'(chan_out), 3);
            chk("R9 done", int'(done), 1);
            @(negedge clk);
            chk("R8 no restart", int'(busy), 0);
        end

        // R9 / R10 result holds and dac parked while idle
        repeat (5) @(negedge clk);
        chk("R9 result hold", int'(result), 700);
        chk("R10 dac idle", int'(dac), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule